// File: doc/BRIEF.md
# Endian-Selectable Width-Down Read Port

This block sits between a 36-bit queue and a read port that can be narrower than the queue. It holds one 36-bit long word at a time. It hands that word out as four 9-bit bytes, two 18-bit halves, or the whole word in one piece. Each read strobe moves the port to the next piece. A new long word is popped from upstream only once the final piece of the held word has been taken, or while nothing is held.

The port width and the piece order are both latched while the full reset is high. After that they stay fixed, whatever the select inputs do. In big-endian order the most significant piece leaves first. In little-endian order the least significant piece leaves first. In long-word width the order select has no effect. Narrow pieces always appear in the low lanes of the 36-bit output, and the unused upper bits read as zero.

A separate partial reset drops the held word and rewinds the piece counter. It keeps the latched width and order.

Top module: `width_down_rdport`

## Requirements
- R1: With `width_sel`=0 (byte), each held long word is delivered as four 9-bit pieces on `rd_data[8:0]`, one per accepted read, with `rd_data[35:9]` zero.
- R2: With `width_sel`=1 (half), each held long word is delivered as two 18-bit pieces on `rd_data[17:0]`, with `rd_data[35:18]` zero.
- R3: With `width_sel`=2 or 3 (long), the full 36-bit word appears in a single read, and `endian_sel` has no effect.
- R4: With `endian_sel`=1 (big), pieces leave from the most significant lane down to the least significant lane.
- R5: With `endian_sel`=0 (little), pieces leave from the least significant lane up to the most significant lane.
- R6: `width_sel` and `endian_sel` are latched on every clock edge at which `rst` is high. While `rst` is low, changes on them have no effect on the output.
- R7: `up_pop` is high in the same cycle, combinationally, exactly when `up_valid` is high, neither reset is high, and either no word is held or `rd_en` consumes the final piece. On the next cycle the popped word's first piece is on `rd_data` with `rd_valid` high.
- R8: `rd_en` while `rd_valid` is low and `up_valid` is low is ignored. The next word fetched starts at its first piece.
- R9: A high `prst` at a clock edge clears `rd_valid`, zeroes `rd_data` and rewinds the piece counter. The latched width and order are kept.
- R10: After `rst`, `rd_valid` is 0 and `rd_data` is 0. While `rst` is high, `up_pop` is 0.

Each cycle in which `rd_valid` is high is one piece on offer. An `rd_en` in that cycle consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full synchronous reset, active high; latches the width and order selects |
| prst | input | 1 | Partial synchronous reset, active high; keeps the latched selects |
| endian_sel | input | 1 | Piece order select: 1 = big, 0 = little |
| width_sel | input | 2 | Port width select: 0 = byte, 1 = half, 2 or 3 = long |
| up_valid | input | 1 | Upstream has a long word available |
| up_data | input | 36 | Upstream long word |
| up_pop | output | 1 | Takes the upstream word in this cycle |
| rd_en | input | 1 | Read strobe: consumes the piece on offer |
| rd_data | output | 36 | Current piece, in the low lanes |
| rd_valid | output | 1 | A piece is on offer |

## Verification
Two functions can fall in the same cycle: consuming the final piece of a held word and popping the next word from upstream. When both happen, the counter must rewind and the new word must load together, with no empty cycle between them. The random phases drive `rd_en` and `up_valid` with high probability, so this overlap recurs many times in every width and order combination. A bench model predicts `up_pop` within the cycle and the first piece of the new word on the following cycle, and both are compared against the design. Partial resets are also injected at random points, including during a pop, to check that the clear wins over a pop in the same cycle.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  typedef enum logic [1:0] {
    PW_BYTE = 2'd0,
    PW_HALF = 2'd1,
    PW_LONG = 2'd2
  } pw_e;

  function automatic pw_e decode_width(input logic [1:0] sel);
    case (sel)
      2'd0:    return PW_BYTE;
      2'd1:    return PW_HALF;
      default: return PW_LONG;
    endcase
  endfunction

  function automatic logic [1:0] last_index(input pw_e m);
    case (m)
      PW_BYTE: return 2'd3;
      PW_HALF: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/rdport_cfg.sv
module rdport_cfg
  import rdport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       endian_in,
  input  logic [1:0] width_in,
  output logic       big_q,
  output pw_e        mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      big_q  <= endian_in;
      mode_q <= decode_width(width_in);
    end
  end

  // R6: selects frozen once reset is released
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(big_q) && $stable(mode_q)));
endmodule

// File: rtl/rdport_seq.sv
module rdport_seq
  import rdport_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  pw_e               mode,
  input  logic              rd_en,
  input  logic              up_valid,
  input  logic [LONG_W-1:0] up_data,
  output logic              up_pop,
  output logic              hold_q,
  output logic [LONG_W-1:0] word_d,
  output logic              hold_d,
  output logic [1:0]        cnt_d
);
  logic [LONG_W-1:0] word_q;
  logic [1:0]        cnt_q;
  logic              last;

  assign last   = (cnt_q == last_index(mode));
  assign up_pop = up_valid && !rst && !prst && (!hold_q || (rd_en && last));

  always_comb begin
    word_d = word_q;
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (rst || prst) begin
      hold_d = 1'b0;
      cnt_d  = 2'd0;
    end else if (up_pop) begin
      word_d = up_data;
      hold_d = 1'b1;
      cnt_d  = 2'd0;
    end else if (rd_en && hold_q) begin
      if (last) begin
        hold_d = 1'b0;
        cnt_d  = 2'd0;
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    word_q <= word_d;
    hold_q <= hold_d;
    cnt_q  <= cnt_d;
  end

  // R7: pop only against an available upstream word
  assert_pop_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    up_pop |-> up_valid);
  // R7: after a pop a word is held at counter zero
  assert_pop_loads_R7: assert property (@(posedge clk) disable iff (rst || prst)
    up_pop |=> (hold_q && cnt_q == 2'd0));
  // R1/R2: counter never passes the last piece
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_index(mode));
  // R9: partial reset empties the holder
  assert_prst_clears_R9: assert property (@(posedge clk) disable iff (rst)
    prst |=> (!hold_q && cnt_q == 2'd0));
  // R8: a read with nothing held and nothing upstream changes nothing
  assert_idle_read_R8: assert property (@(posedge clk) disable iff (rst || prst)
    (rd_en && !hold_q && !up_valid) |=> (!hold_q && cnt_q == 2'd0));
endmodule

// File: rtl/rdport_lane_mux.sv
module rdport_lane_mux
  import rdport_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic [LONG_W-1:0] word,
  input  logic [1:0]        cnt,
  input  pw_e               mode,
  input  logic              big,
  output logic [LONG_W-1:0] piece
);
  localparam int NBYTE = 4;
  localparam int NHALF = 2;
  localparam int BW    = LONG_W / NBYTE;
  localparam int HW    = LONG_W / NHALF;

  logic [BW-1:0] byte_lane [NBYTE];
  logic [HW-1:0] half_lane [NHALF];
  logic [1:0]    byte_idx;
  logic          half_idx;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign byte_lane[i] = word[i*BW +: BW];
  end
  for (genvar j = 0; j < NHALF; j++) begin : g_half
    assign half_lane[j] = word[j*HW +: HW];
  end

  assign byte_idx = big ? (2'd3 - cnt) : cnt;
  assign half_idx = big ? ~cnt[0] : cnt[0];

  always_comb begin
    case (mode)
      PW_BYTE: piece = {{(LONG_W-BW){1'b0}}, byte_lane[byte_idx]};
      PW_HALF: piece = {{(LONG_W-HW){1'b0}}, half_lane[half_idx]};
      default: piece = word;
    endcase
  end
endmodule

// File: rtl/width_down_rdport.sv
module width_down_rdport
  import rdport_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  logic              endian_sel,
  input  logic [1:0]        width_sel,
  input  logic              up_valid,
  input  logic [LONG_W-1:0] up_data,
  output logic              up_pop,
  input  logic              rd_en,
  output logic [LONG_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int BW = LONG_W / 4;
  localparam int HW = LONG_W / 2;

  logic              big_q;
  pw_e               mode_q;
  logic [LONG_W-1:0] word_d;
  logic              hold_d;
  logic [1:0]        cnt_d;
  logic [LONG_W-1:0] piece_d;

  rdport_cfg u_cfg (
    .clk(clk), .rst(rst), .endian_in(endian_sel), .width_in(width_sel),
    .big_q(big_q), .mode_q(mode_q)
  );

  rdport_seq #(.LONG_W(LONG_W)) u_seq (
    .clk(clk), .rst(rst), .prst(prst), .mode(mode_q), .rd_en(rd_en),
    .up_valid(up_valid), .up_data(up_data), .up_pop(up_pop),
    .hold_q(rd_valid), .word_d(word_d), .hold_d(hold_d), .cnt_d(cnt_d)
  );

  rdport_lane_mux #(.LONG_W(LONG_W)) u_mux (
    .word(word_d), .cnt(cnt_d), .mode(mode_q), .big(big_q), .piece(piece_d)
  );

  always_ff @(posedge clk) begin
    if (rst || prst) rd_data <= '0;
    else             rd_data <= hold_d ? piece_d : '0;
  end

  // R1: byte width keeps the upper lanes at zero
  assert_byte_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PW_BYTE) |-> (rd_data[LONG_W-1:BW] == '0));
  // R2: half width keeps the upper lanes at zero
  assert_half_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PW_HALF) |-> (rd_data[LONG_W-1:HW] == '0));
  // R10: no pop during full reset
  assert_no_pop_in_reset_R10: assert property (@(posedge clk)
    rst |-> !up_pop);
endmodule

// File: tb/width_down_rdport_tb.sv
`timescale 1ns/1ps
module width_down_rdport_tb_top;
  logic        clk = 1'b0;
  logic        rst, prst, endian_sel, up_valid, rd_en, up_pop, rd_valid;
  logic [1:0]  width_sel;
  logic [35:0] up_data, rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic        m_big;
  int          m_mode;   // 0 byte, 1 half, 2 long
  logic        m_hv;
  logic [35:0] m_word;
  int          m_cnt;
  logic [35:0] m_data;
  string       tag;

  always #10 clk = ~clk;

  width_down_rdport dut_i (
    .clk(clk), .rst(rst), .prst(prst), .endian_sel(endian_sel),
    .width_sel(width_sel), .up_valid(up_valid), .up_data(up_data),
    .up_pop(up_pop), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic int npieces(int m);
    return (m == 0) ? 4 : (m == 1) ? 2 : 1;
  endfunction

  function automatic logic [35:0] piece_of(logic [35:0] w, int c, int m, logic be);
    int n = npieces(m);
    int pw = 36 / n;
    int idx = be ? (n - 1 - c) : c;
    logic [35:0] r = '0;
    for (int b = 0; b < pw; b++) r[b] = w[idx*pw + b];
    return r;
  endfunction

  function automatic string data_tag();
    string s;
    s = (m_mode == 0) ? "R1" : (m_mode == 1) ? "R2" : "R3";
    if (m_mode != 2) s = {s, m_big ? " R4" : " R5"};
    return s;
  endfunction

  task automatic chk(string t, logic [35:0] act, logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // one cycle: check registered outputs, drive, check pop, clock, update model
  task automatic step(logic r, logic p, logic rv, logic uv);
    logic exp_pop;
    @(negedge clk);
    chk({tag, " valid"}, {35'd0, rd_valid}, {35'd0, m_hv});
    chk({tag, " data ", data_tag()}, rd_data, m_data);
    rst = r; prst = p; rd_en = rv; up_valid = uv;
    #1;
    exp_pop = uv && !r && !p &&
              (!m_hv || (rv && m_cnt == npieces(m_mode) - 1));
    chk(r ? "R10 pop" : "R7 pop", {35'd0, up_pop}, {35'd0, exp_pop});
    @(posedge clk);
    if (r) begin
      m_big = endian_sel;
      m_mode = (width_sel == 2'd0) ? 0 : (width_sel == 2'd1) ? 1 : 2;
      m_hv = 0; m_cnt = 0;
    end else if (p) begin
      m_hv = 0; m_cnt = 0;
    end else if (exp_pop) begin
      m_word = up_data; m_hv = 1; m_cnt = 0;
    end else if (rv && m_hv) begin
      if (m_cnt == npieces(m_mode) - 1) begin m_hv = 0; m_cnt = 0; end
      else m_cnt++;
    end
    m_data = m_hv ? piece_of(m_word, m_cnt, m_mode, m_big) : 36'd0;
    #1;
    if (exp_pop) up_data = {$urandom, $urandom} ;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1; prst = 0; rd_en = 0; up_valid = 0; endian_sel = 0; width_sel = 0;
    up_data = 36'h0;
    m_big = 0; m_mode = 0; m_hv = 0; m_word = '0; m_cnt = 0; m_data = '0;
    tag = "R10";
    for (int cfg = 0; cfg < 8; cfg++) begin
      endian_sel = cfg[0];
      width_sel  = 2'(cfg >> 1);
      up_data    = {$urandom, $urandom};
      tag = "R10";
      step(1, 0, 1, 1);
      step(1, 0, 0, 1);
      // R8: idle reads with nothing held and nothing upstream
      tag = "R8";
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      step(0, 0, 0, 1);
      step(0, 0, 0, 0);
      // R6: flip selects after reset; output must follow latched values
      tag = "R6";
      endian_sel = ~endian_sel;
      width_sel  = width_sel + 2'd1;
      // R7 overlap and random traffic, with rare partial resets (R9)
      for (int k = 0; k < 400; k++) begin
        logic pr;
        pr = ($urandom % 50) == 0;
        tag = pr ? "R9" : "R7";
        if (k % 37 == 0) endian_sel = $urandom;
        step(0, pr, ($urandom % 4) != 0, ($urandom % 5) != 0);
      end
      // R9: directed partial reset while a word is held, config kept
      tag = "R9";
      step(0, 0, 0, 1);
      step(0, 1, 1, 1);
      step(0, 0, 0, 1);
      step(0, 0, 1, 1);
    end
    @(negedge clk);
    chk({tag, " final"}, rd_data, m_data);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule